// File: doc/BRIEF.md
# Branch Trace Memory Writer

This block sits beside a processor core and turns its stream of taken branches into trace records stored in a bounded window of system memory. Each record takes two 32-bit words. The first word holds the branch source address, with a 3-bit branch-type code in its lowest bits. The second word holds the branch destination address. Records go out over a simple request/grant write port. The addresses on that port are physical system-bus addresses and are used exactly as computed; no translation or caching is applied.

Two independent settings choose the behaviour. The first setting decides what happens when the window fills. In overwrite mode the writer returns to the start address, so the newest records replace the oldest. In halt mode it stops capturing, and the core keeps running. The second setting decides what happens when a branch arrives while the previous record is still being written. In lossy mode that branch is discarded and the core never waits. In lossless mode the core is held back until the pending record has been written.

The block does not record two kinds of branch: a conditional branch whose displacement is zero, and the jump to the reset vector caused by a reset. The core flags both kinds on the event port. A status group reports three things: where the next record will go, whether the window has filled, and how many records were lost.

Top module: `brtrace_mem_writer`

## Requirements
- R1: After reset, `mem_req` is 0, `st_wptr` equals `cfg_start`, `st_full` is 0 and `st_drop_cnt` is 0.
- R2: A recorded branch produces two writes, in this order. First, address P receives `{br_src[31:3], br_kind}`, with the branch type in bits 2:0. Then, address P+4 receives `br_dst`.
- R3: Every write address lies in [`cfg_start`, `cfg_end`). Successive records start 8 bytes apart. The window offset is 21 bits wide, which allows a window of up to 1 MB.
- R4: In overwrite mode (`cfg_wrap`=1), the record after the last slot that fits is written at `cfg_start`. `st_full` becomes 1 when the first wrap occurs.
- R5: In halt mode (`cfg_wrap`=0), once the last slot has been written, `st_full` is 1 and `st_wptr` equals `cfg_end`. After that no further writes occur, and each later recordable branch is counted as lost. `br_ready` stays 1 in lossless mode, so the core keeps running.
- R6: In lossy mode (`cfg_stall`=0), `br_ready` is always 1. A recordable branch accepted while a record is pending is discarded and counted as lost.
- R7: In lossless mode (`cfg_stall`=1), `br_ready` is 0 while a record is pending. No branch is ever lost to a collision.
- R8: A branch with `br_cond_zero`=1 or `br_by_reset`=1 produces no write. It leaves `st_wptr` unchanged and does not change `st_drop_cnt`.
- R9: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_addr` and `mem_data` hold their values into the next cycle. A word is transferred in a cycle where both `mem_req` and `mem_gnt` are 1.
- R10: `st_drop_cnt` increases by one for each lost record, never decreases, and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Branch event present |
| br_ready | output | 1 | Branch event accepted on this edge if valid |
| br_src | input | 32 | Branch source address |
| br_dst | input | 32 | Branch destination address |
| br_kind | input | 3 | Branch type code, stored unmodified |
| br_cond_zero | input | 1 | Conditional branch with zero displacement (not recorded) |
| br_by_reset | input | 1 | Jump to the reset vector caused by reset (not recorded) |
| cfg_start | input | 32 | Window start byte address (8-byte aligned) |
| cfg_end | input | 32 | Window end byte address, exclusive (8-byte aligned) |
| cfg_wrap | input | 1 | 1: overwrite oldest records, 0: halt when full |
| cfg_stall | input | 1 | 1: lossless (hold the core), 0: lossy (discard) |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write grant |
| mem_addr | output | 32 | Physical write byte address |
| mem_data | output | 32 | Write data word |
| st_wptr | output | 32 | Address where the next record will be written |
| st_full | output | 1 | Window has filled (halted, or wrapped at least once) |
| st_drop_cnt | output | DROP_W | Saturating count of lost records |

## Verification
The assertions rely on four conditions:
- The window bounds and both mode settings change only while reset is held.
- The window is 8-byte aligned, holds at least one record and spans no more than 1 MB.
- In lossless mode, the branch fields stay steady while `br_valid` waits for `br_ready`.
- The grant only ever answers a pending request.

The stimulus sets the configuration before each reset is released. It drives every event field together at the falling edge and keeps it until acceptance. It uses a 4-record window, so the wrap and halt boundaries are reached within a few branches. It also holds the grant low on purpose so that records collide, which makes the lossy and lossless handling observable.

// File: rtl/btw_pkg.sv
package btw_pkg;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned REC_WORDS  = 2;
  localparam int unsigned REC_BYTES  = WORD_BYTES * REC_WORDS;
  localparam int unsigned KIND_W     = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HEAD = 2'd1,
    SQ_TAIL = 2'd2
  } sq_state_e;
endpackage

// File: rtl/btw_admit.sv
module btw_admit #(
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_cond_zero,
  input  logic              br_by_reset,
  input  logic              cfg_stall,
  input  logic              busy,
  input  logic              stop_full,
  output logic              br_ready,
  output logic              launch,
  output logic [DROP_W-1:0] drop_cnt
);
  logic              take;
  logic              keep;
  logic              drop;
  logic [DROP_W-1:0] cnt_q;
  logic [DROP_W-1:0] cnt_d;
  logic              cnt_en;

  always_comb begin
    br_ready = cfg_stall ? !busy : 1'b1;
    take     = br_valid && br_ready;
    keep     = !(br_cond_zero || br_by_reset);
    launch   = take && keep && !busy && !stop_full;
    drop     = take && keep && (busy || stop_full);
  end

  always_comb begin
    cnt_en = drop && (cnt_q != {DROP_W{1'b1}});
    cnt_d  = cnt_q + {{(DROP_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign drop_cnt = cnt_q;

  // R10: counter never moves backwards
  a_r10_cnt_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q >= $past(cnt_q));
  // R8: filtered branches never start a record
  a_r8_filtered_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (br_cond_zero || br_by_reset) |-> !launch);
  // R7: lossless mode never accepts while a record is pending
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stall && busy) |-> !br_ready);
endmodule

// File: rtl/btw_ptr.sv
module btw_ptr #(
  parameter int unsigned AW    = 32,
  parameter int unsigned OFS_W = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_start,
  input  logic [AW-1:0] cfg_end,
  input  logic          cfg_wrap,
  input  logic          adv,
  output logic [AW-1:0] wptr,
  output logic          full
);
  import btw_pkg::*;

  logic [AW-1:0]    span;
  logic [OFS_W-1:0] len;
  logic [OFS_W-1:0] step;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             full_q, full_d;
  logic             unused_span_hi;

  always_comb begin
    span = cfg_end - cfg_start;
    len  = span[OFS_W-1:0];
    step = ofs_q + OFS_W'(REC_BYTES);
  end

  assign unused_span_hi = ^span[AW-1:OFS_W];

  always_comb begin
    ofs_d  = step;
    full_d = full_q;
    if (step >= len) begin
      full_d = 1'b1;
      ofs_d  = cfg_wrap ? '0 : len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      full_q <= 1'b0;
    end else if (adv) begin
      ofs_q  <= ofs_d;
      full_q <= full_d;
    end
  end

  assign wptr = cfg_start + {{(AW-OFS_W){1'b0}}, ofs_q};
  assign full = full_q;

  // R5: halt mode allows no further record once full
  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !cfg_wrap) |-> !adv);
  // R3: pointer stays inside the window unless halted at the end
  a_r3_ofs_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && !cfg_wrap) |-> (ofs_q < len));
endmodule

// File: rtl/btw_seq.sv
module btw_seq #(
  parameter int unsigned AW     = 32,
  parameter int unsigned KIND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [AW-1:0]     src,
  input  logic [AW-1:0]     dst,
  input  logic [KIND_W-1:0] kind,
  input  logic [AW-1:0]     base,
  input  logic              mem_gnt,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [AW-1:0]     mem_data
);
  import btw_pkg::*;

  sq_state_e     st_q, st_d;
  logic [AW-1:0] head_q, tail_q, addr_q;
  logic [AW-1:0] head_d, tail_d, addr_d;
  logic          load_en, addr_en;
  logic          unused_src_lo;

  assign unused_src_lo = ^src[KIND_W-1:0];

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    addr_en = 1'b0;
    head_d  = {src[AW-1:KIND_W], kind};
    tail_d  = dst;
    addr_d  = addr_q + AW'(WORD_BYTES);
    done    = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (launch) begin
        st_d    = SQ_HEAD;
        load_en = 1'b1;
        addr_d  = base;
        addr_en = 1'b1;
      end
      SQ_HEAD: if (mem_gnt) begin
        st_d    = SQ_TAIL;
        addr_en = 1'b1;
      end
      SQ_TAIL: if (mem_gnt) begin
        st_d = SQ_IDLE;
        done = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (load_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign mem_req  = busy;
  assign mem_addr = addr_q;
  assign mem_data = (st_q == SQ_TAIL) ? tail_q : head_q;

  // R9: an ungranted request holds address and data
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
  // R2: the second word follows the first at the next word address
  a_r2_tail_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_HEAD && mem_gnt) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));
  // R7: a record never starts on top of a pending one
  a_r7_single_pending: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_en);
endmodule

// File: rtl/brtrace_mem_writer.sv
module brtrace_mem_writer #(
  parameter int unsigned AW            = 32,
  parameter int unsigned MAX_WIN_BYTES = 1 << 20,
  parameter int unsigned DROP_W        = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       br_valid,
  output logic                       br_ready,
  input  logic [AW-1:0]              br_src,
  input  logic [AW-1:0]              br_dst,
  input  logic [btw_pkg::KIND_W-1:0] br_kind,
  input  logic                       br_cond_zero,
  input  logic                       br_by_reset,
  input  logic [AW-1:0]              cfg_start,
  input  logic [AW-1:0]              cfg_end,
  input  logic                       cfg_wrap,
  input  logic                       cfg_stall,
  output logic                       mem_req,
  input  logic                       mem_gnt,
  output logic [AW-1:0]              mem_addr,
  output logic [AW-1:0]              mem_data,
  output logic [AW-1:0]              st_wptr,
  output logic                       st_full,
  output logic [DROP_W-1:0]          st_drop_cnt
);
  import btw_pkg::*;

  localparam int unsigned OFS_W = $clog2(MAX_WIN_BYTES) + 1;

  logic busy, launch, done, full, stop_full;
  logic [AW-1:0] wptr;

  assign stop_full = full && !cfg_wrap;

  btw_admit #(.DROP_W(DROP_W)) u_admit (
    .clk         (clk),
    .rst_n       (rst_n),
    .br_valid    (br_valid),
    .br_cond_zero(br_cond_zero),
    .br_by_reset (br_by_reset),
    .cfg_stall   (cfg_stall),
    .busy        (busy),
    .stop_full   (stop_full),
    .br_ready    (br_ready),
    .launch      (launch),
    .drop_cnt    (st_drop_cnt)
  );

  btw_ptr #(.AW(AW), .OFS_W(OFS_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_start(cfg_start),
    .cfg_end  (cfg_end),
    .cfg_wrap (cfg_wrap),
    .adv      (done),
    .wptr     (wptr),
    .full     (full)
  );

  btw_seq #(.AW(AW), .KIND_W(KIND_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .src     (br_src),
    .dst     (br_dst),
    .kind    (br_kind),
    .base    (wptr),
    .mem_gnt (mem_gnt),
    .busy    (busy),
    .done    (done),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .mem_data(mem_data)
  );

  assign st_wptr = wptr;
  assign st_full = full;

  // R3: every request lands inside the programmed window
  a_r3_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= cfg_start && mem_addr < cfg_end));
  // R5: no write traffic once halted full
  a_r5_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    stop_full |-> !mem_req);
  // R6: lossy mode never holds the core
  a_r6_never_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_stall |-> br_ready);
endmodule

// File: tb/tb_brtrace_mem_writer.sv
module tb_brtrace_mem_writer;
  localparam int DW = 3;
  localparam logic [31:0] WSTART = 32'h0000_1000;
  localparam logic [31:0] WEND   = 32'h0000_1020;
  localparam int WLEN = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic br_valid, br_ready, br_cond_zero, br_by_reset;
  logic [31:0] br_src, br_dst;
  logic [2:0] br_kind;
  logic [31:0] cfg_start, cfg_end;
  logic cfg_wrap, cfg_stall;
  logic mem_req, mem_gnt;
  logic [31:0] mem_addr, mem_data, st_wptr;
  logic st_full;
  logic [DW-1:0] st_drop_cnt;

  int checks = 0;
  int fails = 0;
  int gnt_mode = 1;
  int gcnt = 0;
  int m_ofs = 0;
  bit m_full = 0;
  int m_drops = 0;
  string cur_tag = "R2";
  logic [31:0] ea_q[$];
  logic [31:0] ed_q[$];

  always #4 clk = ~clk;

  brtrace_mem_writer #(.DROP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_src(br_src), .br_dst(br_dst), .br_kind(br_kind),
    .br_cond_zero(br_cond_zero), .br_by_reset(br_by_reset),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_wrap(cfg_wrap), .cfg_stall(cfg_stall),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_data(mem_data),
    .st_wptr(st_wptr), .st_full(st_full), .st_drop_cnt(st_drop_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    mem_gnt = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      case (gnt_mode)
        0: mem_gnt = 1'b0;
        1: mem_gnt = 1'b1;
        default: mem_gnt = (gcnt % 3) != 0;
      endcase
      gcnt++;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && mem_req === 1'b1 && mem_gnt === 1'b1) begin
        if (ea_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected write"}, mem_addr, 32'hffff_ffff);
        end else begin
          logic [31:0] ea, ed;
          ea = ea_q.pop_front();
          ed = ed_q.pop_front();
          chk(mem_addr === ea, {cur_tag, " R3 write address"}, mem_addr, ea);
          chk(mem_data === ed, {cur_tag, " R2 write data"}, mem_data, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) act=hung exp=finished");
    report();
  end

  task automatic do_reset(input bit wrap, input bit stall);
    rst_n = 1'b0;
    br_valid = 1'b0; br_cond_zero = 1'b0; br_by_reset = 1'b0;
    br_src = '0; br_dst = '0; br_kind = '0;
    cfg_start = WSTART; cfg_end = WEND; cfg_wrap = wrap; cfg_stall = stall;
    m_ofs = 0; m_full = 0; m_drops = 0;
    ea_q.delete(); ed_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] s, input logic [31:0] d, input logic [2:0] k,
                      input bit cz, input bit rr, input bit lost);
    @(negedge clk);
    br_valid = 1'b1; br_src = s; br_dst = d; br_kind = k;
    br_cond_zero = cz; br_by_reset = rr;
    while (br_ready !== 1'b1) @(negedge clk);
    if (cz || rr) begin
    end else if (lost || (m_full && !cfg_wrap)) begin
      m_drops++;
    end else begin
      ea_q.push_back(WSTART + m_ofs);
      ed_q.push_back({s[31:3], k});
      ea_q.push_back(WSTART + m_ofs + 4);
      ed_q.push_back(d);
      m_ofs += 8;
      if (m_ofs >= WLEN) begin
        m_full = 1'b1;
        m_ofs = cfg_wrap ? 0 : WLEN;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    br_valid = 1'b0; br_cond_zero = 1'b0; br_by_reset = 1'b0;
  endtask

  task automatic drain();
    while (ea_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_drops();
    return (m_drops > 7) ? 32'd7 : 32'(m_drops);
  endfunction

  task automatic check_status(input string tag);
    chk(st_wptr === WSTART + m_ofs, {tag, " st_wptr"}, st_wptr, WSTART + m_ofs);
    chk(st_full === m_full, {tag, " st_full"}, 32'(st_full), 32'(m_full));
    chk(32'(st_drop_cnt) === exp_drops(), {tag, " st_drop_cnt"}, 32'(st_drop_cnt), exp_drops());
  endtask

  initial begin
    // R1: reset state
    do_reset(1'b1, 1'b1);
    chk(mem_req === 1'b0, "R1 mem_req", 32'(mem_req), 0);
    chk(br_ready === 1'b1, "R1 br_ready", 32'(br_ready), 1);
    check_status("R1");

    // R4, R2, R3: overwrite mode, irregular grants, 6 records into a 4-slot window
    cur_tag = "R4";
    gnt_mode = 2;
    for (int i = 0; i < 6; i++) begin
      send(32'h8000_0100 + 32'(i * 16), 32'h8000_2000 + 32'(i * 4), 3'(i + 1), 1'b0, 1'b0, 1'b0);
    end
    idle();
    drain();
    check_status("R4 after wrap");

    // R8: filtered branches leave everything untouched
    cur_tag = "R8";
    send(32'h8000_0300, 32'h8000_0300, 3'd2, 1'b1, 1'b0, 1'b0);
    send(32'h8000_0400, 32'hA000_0000, 3'd5, 1'b0, 1'b1, 1'b0);
    idle();
    repeat (6) @(negedge clk);
    chk(mem_req === 1'b0, "R8 no request", 32'(mem_req), 0);
    check_status("R8");

    // R5, R10: halt mode, lossless, then overflow the counter
    do_reset(1'b0, 1'b1);
    cur_tag = "R5";
    gnt_mode = 1;
    for (int i = 0; i < 6; i++) begin
      send(32'h9000_0000 + 32'(i * 8), 32'h9100_0000 + 32'(i), 3'd7 - 3'(i), 1'b0, 1'b0, 1'b0);
    end
    idle();
    drain();
    chk(br_ready === 1'b1, "R5 core keeps running", 32'(br_ready), 1);
    check_status("R5 halted");
    cur_tag = "R10";
    for (int i = 0; i < 8; i++) begin
      send(32'h9200_0000, 32'h9300_0000, 3'd1, 1'b0, 1'b0, 1'b0);
    end
    idle();
    repeat (3) @(negedge clk);
    check_status("R10 saturated");

    // R6, R9: lossy mode with grant held off
    do_reset(1'b1, 1'b0);
    cur_tag = "R6";
    gnt_mode = 0;
    send(32'h4000_0010, 32'h4000_0800, 3'd3, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      send(32'h4000_0020 + 32'(i * 8), 32'h4000_0900, 3'd4, 1'b0, 1'b0, 1'b1);
      chk(br_ready === 1'b1, "R6 never stalls", 32'(br_ready), 1);
    end
    idle();
    begin
      logic [31:0] a0, d0;
      a0 = mem_addr;
      d0 = mem_data;
      repeat (4) @(negedge clk);
      chk(mem_req === 1'b1, "R9 request held", 32'(mem_req), 1);
      chk(mem_addr === a0, "R9 address held", mem_addr, a0);
      chk(mem_data === d0, "R9 data held", mem_data, d0);
    end
    gnt_mode = 1;
    drain();
    check_status("R6 lossy");

    // R7: lossless mode holds the core while a record is pending
    do_reset(1'b1, 1'b1);
    cur_tag = "R7";
    gnt_mode = 0;
    send(32'h5000_0000, 32'h5000_1000, 3'd6, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    br_valid = 1'b1; br_src = 32'h5000_0040; br_dst = 32'h5000_2000; br_kind = 3'd2;
    for (int i = 0; i < 3; i++) begin
      chk(br_ready === 1'b0, "R7 ready low while pending", 32'(br_ready), 0);
      @(negedge clk);
    end
    gnt_mode = 1;
    send(32'h5000_0040, 32'h5000_2000, 3'd2, 1'b0, 1'b0, 1'b0);
    idle();
    drain();
    check_status("R7 lossless");

    report();
  end
endmodule